// File: doc/BRIEF.md
# Dual-Width Pulse Generator

This block produces rectangular waveforms from two down-counting reload counters, each one byte wide. Each counter owns two reload values: one sets how long its output stays low, the other how long it stays high. On every underflow the output flips and the counter reloads the width of the phase it is entering. The low and high times can therefore be set independently. With a width value of N, a phase lasts N+1 count-clock ticks.

A mode input decides how the two counters work together. In split mode they are two separate generators. In wide mode they join into one 16-bit counter on the second output. In cascade mode the first counter acts as a programmable prescaler, and each of its underflows clocks the second counter. One shared clock-select input sets the count clock. It can be the system clock, the system clock divided by 2, 4, 8 or 16, or a slow tick with a parameterised period. All dividers restart when the block leaves the fully idle state, so the tick train lines up with the start of a run.

Top module: `pgen_pair`

## Requirements
- R1: After reset both pulse outputs are low and both interrupt flags are clear.
- R2: When a channel starts (its effective run goes high), its output is low from that edge on. The low phase lasts lo+1 count ticks and the high phase hi+1 ticks, and the two phases alternate for as long as the channel runs.
- R3: clk_sel codes 0 to 4 give a count tick every 2^code system cycles. Codes 5, 6 and 7 give one every SLOW_DIV cycles. Ticks fall on whole multiples of that period, counted from the edge where the first channel starts after all were idle.
- R4: Mode codes 0 and 3 (split) run two independent byte-wide generators. Channel 0 runs while run[0] is high and channel 1 runs while run[1] is high. Starting or stopping one channel does not disturb the other.
- R5: Mode code 1 (wide) drives pulse[1] from a 16-bit counter. Its low width is {ch1 low, ch0 low} and its high width is {ch1 high, ch0 high}, with the channel 1 byte in the upper half. run[1] controls it, and pulse[0] stays low.
- R6: In mode code 2 (cascade), channel 0 counts the selected tick and drives pulse[0]. Channel 1 counts only channel 0 underflows and drives pulse[1]. run[1] starts and stops both channels, and run[0] is ignored.
- R7: A width written while a channel runs does not change the phase in progress. The new value applies from the next phase of that kind.
- R8: If irq_en[i] is set, each underflow of channel i sets irq[i]. If irq_en[i] is clear, the flag is not set.
- R9: A one-cycle pulse on irq_clr[i] clears irq[i]. If an enabled underflow happens in the same cycle, the flag stays set.
- R10: Dropping a channel's effective run forces its output low on the next edge. Stopping does not change the interrupt flags.
- R11: The write address selects the width register as follows: 0 = channel 0 low, 1 = channel 0 high, 2 = channel 1 low, 3 = channel 1 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Count clock choice |
| mode | input | 2 | Pairing mode |
| run | input | 2 | Per-channel run levels |
| wr_en | input | 1 | Width register write strobe |
| wr_addr | input | 2 | Width register select |
| wr_data | input | 8 | Width value |
| irq_en | input | 2 | Per-channel interrupt enable |
| irq_clr | input | 2 | Per-channel flag clear pulse |
| pulse | output | 2 | Waveform outputs |
| irq | output | 2 | Per-channel interrupt flags |

## Verification
The assertions assume that mode and clk_sel change only while both run bits are low. They also assume SLOW_DIV is at least 2, so that the divided ticks never come on back-to-back cycles during a run. The stimulus honours this by changing mode, clk_sel and the width registers only between runs. The one exception is the deliberate mid-run width writes. Randomised runs are spaced by an idle gap, so the dividers restart cleanly each time.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int CW       = 8;
  localparam int DIV_BITS = 4;

  typedef enum logic [1:0] {
    PM_SPLIT   = 2'd0,
    PM_WIDE    = 2'd1,
    PM_CASCADE = 2'd2,
    PM_SPLIT_B = 2'd3
  } pmode_e;

  // low-order mask that must be zero on a tick for divide-by-2^sel
  function automatic logic [DIV_BITS-1:0] div_mask(input logic [2:0] sel);
    return DIV_BITS'((32'd1 << sel) - 32'd1);
  endfunction

  function automatic logic sel_is_slow(input logic [2:0] sel);
    return sel >= 3'd5;
  endfunction

  // reload width for the upper channel: joined in wide mode, zero-extended otherwise
  function automatic logic [2*CW-1:0] join_width(input logic wide,
                                                 input logic [CW-1:0] upper,
                                                 input logic [CW-1:0] lower);
    return wide ? {upper, lower} : {{CW{1'b0}}, upper};
  endfunction
endpackage

// File: rtl/pgen_tick.sv
module pgen_tick
  import pgen_pkg::*;
#(
  parameter int SLOW_DIV = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [DIV_BITS-1:0] div_q;
  logic [SW-1:0]       slow_q;
  logic                slow_wrap;

  assign slow_wrap = (slow_q == SW'(SLOW_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q  <= '0;
      slow_q <= '0;
    end else begin
      div_q  <= div_q + DIV_BITS'(1);
      slow_q <= slow_wrap ? '0 : slow_q + SW'(1);
    end
  end

  assign tick = sel_is_slow(sel) ? (slow_q == '0)
                                 : ((div_q & div_mask(sel)) == '0);

  // R3: divided ticks never arrive on consecutive running cycles
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (en && tick && sel != 3'd0) |=> (!tick || !$stable(sel) || !$past(en)));
endmodule

// File: rtl/pgen_chan.sv
module pgen_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] lo_w,
  input  logic [W-1:0] hi_w,
  output logic         out,
  output logic         uf
);
  logic         active_q;
  logic         lvl_q;
  logic [W-1:0] cnt_q;

  // underflow event, brought out for the flag logic and the checks
  assign uf  = run && active_q && tick && (cnt_q == '0);
  assign out = lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      lvl_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (!run) begin
      active_q <= 1'b0;
      lvl_q    <= 1'b0;
    end else if (!active_q) begin
      active_q <= 1'b1;
      lvl_q    <= 1'b0;
      cnt_q    <= lo_w;
    end else if (tick) begin
      if (cnt_q == '0) begin
        lvl_q <= ~lvl_q;
        cnt_q <= lvl_q ? lo_w : hi_w;
      end else begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  // R10: stopping drives the output low
  a_r10_stop_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !out);
  // R2: a fresh start begins in the low phase
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    (run && !active_q) |=> !out);
  // R2: the output moves only on an underflow
  a_r2_hold_level: assert property (@(posedge clk) disable iff (rst)
    (run && active_q && !uf) |=> (out == $past(out)));
  // R2: every underflow flips the output
  a_r2_flip: assert property (@(posedge clk) disable iff (rst)
    uf |=> (out != $past(out)));
endmodule

// File: rtl/pgen_pair.sv
module pgen_pair
  import pgen_pkg::*;
#(
  parameter int SLOW_DIV = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    clk_sel,
  input  logic [1:0]    mode,
  input  logic [1:0]    run,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    irq_en,
  input  logic [1:0]    irq_clr,
  output logic [1:0]    pulse,
  output logic [1:0]    irq
);
  localparam int NREG = 4;
  localparam int WW   = 2 * CW;

  pmode_e       mode_e;
  logic [CW-1:0] wreg_q [NREG];
  logic          run0_e, run1_e, any_run;
  logic          base_tick, tick1;
  logic [1:0]    uf;
  logic [1:0]    irq_q;
  logic [WW-1:0] lo1, hi1;
  logic          wide;

  assign mode_e = pmode_e'(mode);
  assign wide   = (mode_e == PM_WIDE);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) wreg_q[i] <= '0;
    end else if (wr_en) begin
      wreg_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    case (mode_e)
      PM_WIDE:    run0_e = 1'b0;
      PM_CASCADE: run0_e = run[1];
      default:    run0_e = run[0];
    endcase
  end
  assign run1_e  = run[1];
  assign any_run = run0_e || run1_e;

  pgen_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk (clk), .rst (rst), .en (any_run), .sel (clk_sel), .tick (base_tick)
  );

  assign tick1 = (mode_e == PM_CASCADE) ? uf[0] : base_tick;
  assign lo1   = join_width(wide, wreg_q[2], wreg_q[0]);
  assign hi1   = join_width(wide, wreg_q[3], wreg_q[1]);

  pgen_chan #(.W(CW)) u_ch0 (
    .clk (clk), .rst (rst), .run (run0_e), .tick (base_tick),
    .lo_w (wreg_q[0]), .hi_w (wreg_q[1]), .out (pulse[0]), .uf (uf[0])
  );

  pgen_chan #(.W(WW)) u_ch1 (
    .clk (clk), .rst (rst), .run (run1_e), .tick (tick1),
    .lo_w (lo1), .hi_w (hi1), .out (pulse[1]), .uf (uf[1])
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)                        irq_q[g] <= 1'b0;
        else if (uf[g] && irq_en[g])    irq_q[g] <= 1'b1;
        else if (irq_clr[g])            irq_q[g] <= 1'b0;
      end

      // R8: an enabled underflow raises the flag
      a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
        (uf[g] && irq_en[g]) |=> irq[g]);
      // R9: a clear without a competing underflow drops the flag
      a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (irq_clr[g] && !(uf[g] && irq_en[g])) |=> !irq[g]);
    end
  endgenerate

  assign irq = irq_q;

  // R5: in wide mode the lower output stays low
  a_r5_wide_low: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && $past(mode) == 2'd1) |-> !pulse[0]);
endmodule

// File: tb/sim_pgen_pair.sv
`timescale 1ns/1ps
module sim_pgen_pair;
  localparam int SLOW = 6;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] clk_sel;
  logic [1:0] mode, run, wr_addr, irq_en, irq_clr, pulse, irq;
  logic       wr_en;
  logic [7:0] wr_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgen_pair #(.SLOW_DIV(SLOW)) u0 (
    .clk (clk), .rst (rst), .clk_sel (clk_sel), .mode (mode), .run (run),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .irq_en (irq_en), .irq_clr (irq_clr), .pulse (pulse), .irq (irq)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // number of output flips after c count ticks for widths lo/hi
  function automatic int flips(int c, int lo, int hi);
    int n = 0;
    int r = c;
    bit ph = 0;
    while (r >= (ph ? hi : lo) + 1) begin
      r -= (ph ? hi : lo) + 1;
      n++;
      ph = !ph;
    end
    return n;
  endfunction

  function automatic int tick_period(int sel);
    return (sel < 5) ? (1 << sel) : SLOW;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic stop_all();
    run = 2'b00;
    step();
    chk(pulse[0], 1'b0, "R10", "pulse0 after stop");
    chk(pulse[1], 1'b0, "R10", "pulse1 after stop");
    step();
  endtask

  task automatic sweep(input int md, input int sel, input int l0, input int h0,
                       input int l1, input int h1, input int cycles, input string req);
    int p, c, t0, e0, e1;
    wr(0, l0); wr(1, h0); wr(2, l1); wr(3, h1);
    mode = 2'(md); clk_sel = 3'(sel);
    run = (md == 2) ? 2'b10 : 2'b11;
    p = tick_period(sel);
    for (int m = 0; m < cycles; m++) begin
      step();
      c = m / p;
      if (md == 1) begin
        e0 = 0;
        e1 = flips(c, l1 * 256 + l0, h1 * 256 + h0) & 1;
      end else if (md == 2) begin
        t0 = flips(c, l0, h0);
        e0 = t0 & 1;
        e1 = flips(t0, l1, h1) & 1;
      end else begin
        e0 = flips(c, l0, h0) & 1;
        e1 = flips(c, l1, h1) & 1;
      end
      chk(pulse[0], 1'(e0), req, $sformatf("pulse0 mode=%0d sel=%0d m=%0d", md, sel, m));
      chk(pulse[1], 1'(e1), req, $sformatf("pulse1 mode=%0d sel=%0d m=%0d", md, sel, m));
    end
    stop_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int e0, e1;
    void'($urandom(32'h5eed));
    rst = 1'b1; clk_sel = 3'd0; mode = 2'd0; run = 2'b00; wr_en = 1'b0;
    wr_addr = 2'd0; wr_data = 8'd0; irq_en = 2'b00; irq_clr = 2'b00;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(pulse[0], 1'b0, "R1", "pulse0 after reset");
    chk(pulse[1], 1'b0, "R1", "pulse1 after reset");
    chk(irq[0], 1'b0, "R1", "irq0 after reset");
    chk(irq[1], 1'b0, "R1", "irq1 after reset");

    // R2 R3 R4 directed split runs across clock choices
    sweep(0, 0, 2, 4, 0, 1, 60, "R2,R4");
    sweep(0, 2, 1, 0, 3, 2, 120, "R3");
    sweep(0, 6, 0, 2, 1, 1, 150, "R3");
    sweep(3, 1, 3, 1, 2, 2, 80, "R4");
    // R5 R11 wide run: low width 0x0102, high width 0x0003
    sweep(1, 0, 2, 3, 1, 0, 600, "R5,R11");
    // R6 cascade
    sweep(2, 1, 1, 2, 0, 1, 120, "R6");

    // R4 staggered starts and an independent stop
    wr(0, 2); wr(1, 1); wr(2, 1); wr(3, 3);
    mode = 2'd0; clk_sel = 3'd0; run = 2'b01;
    for (int m = 0; m < 40; m++) begin
      step();
      e0 = (m > 20) ? 0 : (flips(m, 2, 1) & 1);
      e1 = (m < 3) ? 0 : (flips(m - 3, 1, 3) & 1);
      chk(pulse[0], 1'(e0), "R4", $sformatf("stagger pulse0 m=%0d", m));
      chk(pulse[1], 1'(e1), "R4", $sformatf("stagger pulse1 m=%0d", m));
      if (m == 2) run[1] = 1'b1;
      if (m == 20) run[0] = 1'b0;
    end
    stop_all();

    // R7 width writes during a run
    wr(0, 5); wr(1, 5);
    mode = 2'd0; clk_sel = 3'd0; run = 2'b01;
    for (int m = 0; m < 40; m++) begin
      step();
      wr_en = 1'b0;
      e0 = ((m >= 6 && m < 12) || (m >= 33 && m < 36)) ? 1 : 0;
      chk(pulse[0], 1'(e0), "R7", $sformatf("mid-run write m=%0d", m));
      if (m == 1) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd20; end
      if (m == 7) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd2; end
    end
    stop_all();

    // R8 R9 R10 interrupt flags
    wr(0, 3); wr(1, 3); wr(2, 1); wr(3, 1);
    mode = 2'd0; clk_sel = 3'd0; irq_en = 2'b01; run = 2'b11;
    for (int m = 0; m <= 14; m++) begin
      step();
      irq_clr = 2'b00;
      if (m == 3)  chk(irq[0], 1'b0, "R8", "flag before first underflow");
      if (m == 4)  chk(irq[0], 1'b1, "R8", "flag at first underflow");
      if (m == 3)  chk(irq[1], 1'b0, "R8", "disabled channel flag");
      if (m == 6)  chk(irq[0], 1'b0, "R9", "flag after clear");
      if (m == 8)  chk(irq[0], 1'b1, "R8", "flag set again");
      if (m == 12) chk(irq[0], 1'b1, "R9", "set wins over clear");
      if (m == 14) begin
        chk(irq[0], 1'b1, "R10", "flag kept on stop");
        chk(pulse[0], 1'b0, "R10", "pulse0 low on stop");
      end
      if (m == 5 || m == 11) irq_clr = 2'b01;
      if (m == 13) run = 2'b00;
    end
    irq_clr = 2'b01; step(); irq_clr = 2'b00;
    chk(irq[0], 1'b0, "R9", "flag cleared while idle");
    irq_en = 2'b00;
    step();

    // constrained random runs
    for (int k = 0; k < 14; k++) begin
      int md, sel, l0, h0, l1, h1;
      md  = int'($urandom % 4);
      sel = int'($urandom % 8);
      l0  = int'($urandom % 6); h0 = int'($urandom % 6);
      l1  = (md == 1) ? int'($urandom % 2) : int'($urandom % 6);
      h1  = (md == 1) ? int'($urandom % 2) : int'($urandom % 6);
      sweep(md, sel, l0, h0, l1, h1, 250, "R2,R3");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule